// File: doc/BRIEF.md
# Pipelined GF(2) Modular Polynomial Multiplier

This block multiplies two binary polynomials, a multiplicand and a multiplier, and reduces the product modulo a third polynomial supplied at run time. All coefficients are in GF(2), so every addition is a carry-free XOR. Because the modulus is an input and not a constant, one instance serves every base of a polynomial residue-number-system cipher, whatever the degree of that base up to `WIDTH`.

A one-cycle `start` pulse captures the modulus, multiplicand and multiplier into holding registers. An unrolled array of `WIDTH` stage cells then consumes the multiplier bits from the most significant to the least significant. Each cell shifts the running remainder up by one place, XORs in the multiplicand gated by the current multiplier bit, and subtracts the modulus once if the coefficient at the modulus degree is set. A register follows every cell, so a new operand set may be presented on every clock. A copy of `start` runs down a shift register beside the data and marks the cycle in which each result appears. Between results, the output holds the most recent one.

The caller must keep both operands of lower degree than the modulus. The modulus degree is found from its highest set bit, and bits above that degree must be zero.

Top module: `gfmul_top`

## Requirements
- R1: With the modulus degree d between 1 and WIDTH, and both operands of degree below d, `result` equals multiplicand times multiplier reduced modulo `modulus`, all arithmetic carry-free over GF(2). The bit at index i of each bus is the coefficient of x^i.
- R2: `resultValid` goes high after the WIDTH-th rising clock edge that follows the edge at which `start` was sampled high, and stays high for one cycle per start.
- R3: A start may be given on every consecutive cycle. Results then appear on consecutive cycles in the order the starts were given, each with its own operands.
- R4: `resultValid` is never high in a cycle that does not correspond to an earlier start. A reset discards every operation still in flight.
- R5: While `rstN` is low and just after it rises, `resultValid` is 0 and `result` is 0.
- R6: While `resultValid` is low, `result` keeps its previous value, whatever the operand inputs do.
- R7: A zero multiplicand or a zero multiplier gives a zero result.
- R8: A multiplier equal to 1 gives the multiplicand unchanged as the result.
- R9: The operand inputs are sampled only in the cycle where `start` is high. Changing them in later cycles does not affect the result of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request that captures the three operand buses |
| modulus | input | WIDTH+1 | Reducing polynomial, highest set bit gives its degree |
| multiplicand | input | WIDTH | First factor, degree below that of the modulus |
| multiplier | input | WIDTH | Second factor, degree below that of the modulus |
| result | output | WIDTH | Reduced product, held between results |
| resultValid | output | 1 | High for one cycle when a new result is on `result` |

## Verification
A wrong remainder in any stage cell or pipeline register gets to `result` in exactly WIDTH cycles. It shows as a value that differs from the reference product, or as a value of the same or higher degree than the modulus. Any mistake in the start chain shows as a valid pulse one cycle early or late, a missing pulse, or a pulse after reset. Back-to-back streaming exposes a register that is skipped or holds its value for two cycles, because neighbouring results then swap or repeat. Scrambling the operand inputs right after each start exposes a stage that reads the live ports and not its own captured copy.

// File: rtl/gfmul_pkg.sv
package gfmul_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;   // load the operand holding registers
    logic publish;   // load the final remainder into the output register
  } gfmulStrobe_t;

endpackage

// File: rtl/gfmul_stage.sv
// One cell of the unrolled array: shift, gated add, conditional reduce.
module gfmul_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] prevRem,
  input  logic [WIDTH-1:0] modLow,
  input  logic [WIDTH:0]   leadMask,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic             coeff,
  output logic [WIDTH-1:0] nextRem
);
  localparam int unsigned PW = WIDTH + 1;

  logic [PW-1:0] shifted;
  logic [PW-1:0] summed;
  logic          overDegree;

  always_comb begin
    shifted    = {prevRem, 1'b0};
    summed     = shifted ^ {1'b0, multiplicand & {WIDTH{coeff}}};
    overDegree = |(summed & leadMask);
    // The bit at the degree of the modulus cancels and is dropped.
    // Bits above that degree are already zero.
    nextRem    = summed[WIDTH-1:0] ^ (modLow & {WIDTH{overDegree}});
  end

endmodule

// File: rtl/gfmul_ctrl.sv
// Start chain: tracks each operation down the pipeline.
module gfmul_ctrl
  import gfmul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output gfmulStrobe_t strobe,
  output logic         resultValid
);
  localparam int unsigned DEPTH = WIDTH + 1;

  logic [DEPTH-1:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= {inFlight[DEPTH-2:0], start};
  end

  assign strobe.capture = start;
  assign strobe.publish = inFlight[DEPTH-2];
  assign resultValid    = inFlight[DEPTH-1];

endmodule

// File: rtl/gfmul_datapath.sv
// Operand capture, unrolled stage array and output register.
module gfmul_datapath
  import gfmul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gfmulStrobe_t     strobe,
  input  logic [WIDTH:0]   modulus,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] result
);
  localparam int unsigned PW = WIDTH + 1;

  // One-hot marker of the modulus degree
  logic [PW-1:0] leadIn;
  always_comb begin
    leadIn = '0;
    for (int i = 0; i < PW; i++) begin
      if (modulus[i]) begin
        leadIn    = '0;
        leadIn[i] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic [WIDTH-1:0]   inP;
    logic [WIDTH-1:0]   inA;
    logic [PW-1:0]      inM;
    logic [WIDTH-1-k:0] inB;      // multiplier bits not yet consumed
    logic [WIDTH-1:0]   prevRem;
    logic [WIDTH-1:0]   nextRem;
    logic [WIDTH-1:0]   remQ;

    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inP <= '0;
          inA <= '0;
          inM <= '0;
          inB <= '0;
        end else if (strobe.capture) begin
          inP <= modulus[WIDTH-1:0];
          inA <= multiplicand;
          inM <= leadIn;
          inB <= multiplier;
        end
      end
      assign prevRem = '0;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inP <= '0;
          inA <= '0;
          inM <= '0;
          inB <= '0;
        end else begin
          inP <= g_stage[k-1].inP;
          inA <= g_stage[k-1].inA;
          inM <= g_stage[k-1].inM;
          inB <= g_stage[k-1].inB[WIDTH-1-k:0];
        end
      end
      assign prevRem = g_stage[k-1].remQ;
    end

    gfmul_stage #(.WIDTH(WIDTH)) u_cell (
      .prevRem      (prevRem),
      .modLow       (inP),
      .leadMask     (inM),
      .multiplicand (inA),
      .coeff        (inB[WIDTH-1-k]),
      .nextRem      (nextRem)
    );

    if (k < WIDTH - 1) begin : g_pipe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) remQ <= '0;
        else       remQ <= nextRem;
      end
    end else begin : g_out
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               remQ <= '0;
        else if (strobe.publish) remQ <= nextRem;
      end
    end
  end

  assign result = g_stage[WIDTH-1].remQ;

endmodule

// File: rtl/gfmul_top.sv
module gfmul_top
  import gfmul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH:0]   modulus,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] result,
  output logic             resultValid
);
  gfmulStrobe_t strobe;

  gfmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  gfmul_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .modulus      (modulus),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .result       (result)
  );

endmodule

// File: rtl/gfmul_checker.sv
module gfmul_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH:0]   modulus,
  input logic [WIDTH-1:0] multiplicand,
  input logic [WIDTH-1:0] multiplier,
  input logic [WIDTH-1:0] result,
  input logic             resultValid
);
  localparam int unsigned DEPTH = WIDTH + 1;

  // Shadow of each request, aged one slot per clock
  logic             shStart [DEPTH];
  logic [WIDTH:0]   shMod   [DEPTH];
  logic [WIDTH-1:0] shA     [DEPTH];
  logic             shZero  [DEPTH];
  logic             shOne   [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        shStart[i] <= 1'b0;
        shMod[i]   <= '0;
        shA[i]     <= '0;
        shZero[i]  <= 1'b0;
        shOne[i]   <= 1'b0;
      end
    end else begin
      shStart[0] <= start;
      shMod[0]   <= modulus;
      shA[0]     <= multiplicand;
      shZero[0]  <= (multiplicand == '0) || (multiplier == '0);
      shOne[0]   <= (multiplier == WIDTH'(1));
      for (int i = 1; i < DEPTH; i++) begin
        shStart[i] <= shStart[i-1];
        shMod[i]   <= shMod[i-1];
        shA[i]     <= shA[i-1];
        shZero[i]  <= shZero[i-1];
        shOne[i]   <= shOne[i-1];
      end
    end
  end

  // R2 and R4: a valid pulse appears exactly when a start has aged WIDTH edges
  a_r2_valid_timing: assert property (@(posedge clk) disable iff (!rstN)
    resultValid == shStart[DEPTH-1]);

  // R1: a delivered remainder is always below its modulus
  a_r1_below_modulus: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && shStart[DEPTH-1] |-> ({1'b0, result} < shMod[DEPTH-1]));

  // R6: no change on the output without a valid pulse
  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R7: zero operand gives zero
  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && shZero[DEPTH-1] |-> result == '0);

  // R8: unit multiplier returns the multiplicand
  a_r8_unit_multiplier: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && shOne[DEPTH-1] && !shZero[DEPTH-1] |-> result == shA[DEPTH-1]);

endmodule

bind gfmul_top gfmul_checker #(.WIDTH(WIDTH)) u_gfmulChecker (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .modulus      (modulus),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .result       (result),
  .resultValid  (resultValid)
);

// File: tb/tb_gfmul_top.sv
module tb_gfmul_top;
  localparam int WIDTH      = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;
  localparam int NSTREAM    = 20;

  logic             clk = 1'b0;
  logic             rstN;
  logic             start;
  logic [WIDTH:0]   modulus;
  logic [WIDTH-1:0] multiplicand;
  logic [WIDTH-1:0] multiplier;
  logic [WIDTH-1:0] result;
  logic             resultValid;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfmul_top #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .start(start), .modulus(modulus),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .result(result), .resultValid(resultValid)
  );

  // {modulus, multiplicand, multiplier, expected}
  localparam logic [32:0] VEC [NVEC] = '{
    {9'h025, 8'h13, 8'h15, 8'h0D},
    {9'h11B, 8'h57, 8'h83, 8'hC1},
    {9'h11B, 8'h57, 8'h13, 8'hFE},
    {9'h11B, 8'h53, 8'hCA, 8'h01},
    {9'h013, 8'h02, 8'h08, 8'h03},
    {9'h025, 8'h10, 8'h02, 8'h05},
    {9'h007, 8'h02, 8'h02, 8'h03},
    {9'h11B, 8'hA6, 8'h00, 8'h00},
    {9'h11B, 8'h00, 8'hE3, 8'h00},
    {9'h11B, 8'hA6, 8'h01, 8'hA6}
  };

  localparam logic [8:0] MODS [6] = '{9'h007, 9'h00B, 9'h013, 9'h025, 9'h11B, 9'h11D};

  function automatic logic [8:0] topBit(input logic [8:0] p);
    logic [8:0] t = '0;
    for (int i = 0; i < 9; i++) if (p[i]) begin t = '0; t[i] = 1'b1; end
    return t;
  endfunction

  // Reference: least-significant-first shift and add
  function automatic logic [7:0] refMul(input logic [8:0] p, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] acc = '0;
    logic [8:0] sh  = {1'b0, a};
    logic [8:0] t   = topBit(p);
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh << 1;
      if ((sh & t) != '0) sh = sh ^ p;
    end
    return acc[7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [8:0] p, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] r, output int lat);
    @(negedge clk);
    modulus = p; multiplicand = a; multiplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    modulus = ~p; multiplicand = ~a; multiplier = ~b;   // R9 scramble
    lat = -1;
    for (int c = 1; c <= 4*WIDTH; c++) begin
      @(negedge clk);
      if (resultValid) begin lat = c; break; end
    end
    r = result;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      checkCount++; failCount++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] held;
    logic [7:0] expQ [NSTREAM];
    logic [8:0] smod [NSTREAM];
    logic [7:0] sa [NSTREAM];
    logic [7:0] sb [NSTREAM];
    int lat;

    rstN = 1'b0; start = 1'b0; modulus = '0; multiplicand = '0; multiplier = '0;
    repeat (3) @(negedge clk);
    check(resultValid == 1'b0, "R5 valid in reset", 32'(resultValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid == 1'b0, "R5 valid after reset", 32'(resultValid), 0);
    check(result == '0, "R5 result after reset", 32'(result), 0);

    // Table walk: R1, R7, R8, R2, R4, R9
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] p;
      logic [7:0] a, b, e;
      {p, a, b, e} = VEC[v];
      runOp(p, a, b, r, lat);
      if (a == 0 || b == 0)  check(r == e, "R7 zero operand", 32'(r), 32'(e));
      else if (b == 1)       check(r == e, "R8 unit multiplier", 32'(r), 32'(e));
      else if (v == 0)       check(r == e, "R9 inputs scrambled after start", 32'(r), 32'(e));
      else                   check(r == e, "R1 table product", 32'(r), 32'(e));
      check(lat == WIDTH, "R2 latency", 32'(lat), 32'(WIDTH));
      @(negedge clk);
      check(resultValid == 1'b0, "R4 single valid pulse", 32'(resultValid), 0);
    end

    // Second worked vector, against the reference
    runOp(9'h11B, 8'hA6, 8'hE3, r, lat);
    check(r == refMul(9'h11B, 8'hA6, 8'hE3), "R1 A6*E3", 32'(r), 32'(refMul(9'h11B, 8'hA6, 8'hE3)));

    // Random operands over moduli of several degrees
    for (int m = 0; m < 6; m++) begin
      for (int n = 0; n < 5; n++) begin
        logic [8:0] lim;
        logic [7:0] a, b;
        lim = topBit(MODS[m]) - 9'd1;
        a = 8'($urandom) & lim[7:0];
        b = 8'($urandom) & lim[7:0];
        runOp(MODS[m], a, b, r, lat);
        check(r == refMul(MODS[m], a, b), "R1 random product", 32'(r), 32'(refMul(MODS[m], a, b)));
      end
    end

    // R6: output holds while no valid, inputs wiggling
    held = result;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      modulus = 9'($urandom); multiplicand = 8'($urandom); multiplier = 8'($urandom);
      check(result == held && !resultValid, "R6 hold without valid", 32'(result), 32'(held));
    end

    // R3: back-to-back stream
    for (int j = 0; j < NSTREAM; j++) begin
      logic [8:0] lim;
      smod[j] = MODS[j % 6];
      lim     = topBit(smod[j]) - 9'd1;
      sa[j]   = 8'($urandom) & lim[7:0];
      sb[j]   = 8'($urandom) & lim[7:0];
      expQ[j] = refMul(smod[j], sa[j], sb[j]);
    end
    repeat (WIDTH + 2) @(negedge clk);
    for (int i = 0; i <= NSTREAM + WIDTH; i++) begin
      @(negedge clk);
      if (i >= WIDTH + 1 && i - WIDTH - 1 < NSTREAM) begin
        check(resultValid == 1'b1, "R3 stream valid", 32'(resultValid), 1);
        check(result == expQ[i-WIDTH-1], "R3 stream result", 32'(result), 32'(expQ[i-WIDTH-1]));
      end else if (i > 0) begin
        check(resultValid == 1'b0, "R4 stream fill", 32'(resultValid), 0);
      end
      if (i < NSTREAM) begin
        modulus = smod[i]; multiplicand = sa[i]; multiplier = sb[i]; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;

    // R4/R5: reset discards an operation in flight
    @(negedge clk);
    modulus = 9'h11B; multiplicand = 8'h57; multiplier = 8'h83; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 2*WIDTH; c++) begin
      @(negedge clk);
      check(resultValid == 1'b0, "R4 no valid after reset", 32'(resultValid), 0);
    end
    check(result == '0, "R5 result cleared by reset", 32'(result), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule